// File: doc/BRIEF.md
# Serial EEPROM Write-Completion Controller

This block decides the moment at which a serial EEPROM port declares an operation finished. It sits beside the bit shifter and watches its end-of-transfer strobe. It raises a busy flag when an access starts and clears it on completion. At completion it issues an interrupt pulse and a system-management request pulse.

A write does not end when its last bit leaves the shifter, because the device then runs its own internally timed programming cycle. The block handles this in one of two ways, chosen by a mode input sampled at the end of each write. In the fast mode, completion is reported at once and the device is polled before the following access: the controller sends address probes until one is acknowledged. In the timed mode, completion is held back for 10.24 ms, counted with a prescaled 10 µs tick. The busy flag stays high and both interrupt pulses wait until the delay expires. After that, no polling is needed.

Requests for a new access are remembered while the block is busy and are served as soon as it goes idle.

Top module: `eeprom_wdone`

## Requirements
- R1: At the end of a write in fast mode (`timedWrite`=0), `busy` falls and `irqPulse` rises in the cycle right after the one where `lastBitDone` is sampled.
- R2: A read ends like R1 (completion in the next cycle) whatever the value of `timedWrite`, and it arms no polling: the following request gets `accessStart` one cycle later with no `probeStart`.
- R3: After a fast-mode write, the next request gives a `probeStart` pulse one cycle later and no `accessStart`. A `probeDone` with `probeAck`=1 gives `accessStart` in the following cycle.
- R4: A `probeDone` with `probeAck`=0 gives a new `probeStart` in the next cycle. On the MAX_RETRY-th consecutive refusal the block instead pulses `pollTimeout`, drops `busy`, raises no interrupt and starts no access, and it discards the pending poll.
- R5: At the end of a write in timed mode, `irqPulse` appears exactly DELAY_TICKS × (CLK_KHZ/100) cycles after the cycle where `lastBitDone` is sampled. DELAY_TICKS is 1024 ticks of 10 µs, 10.24 ms in total. `busy` stays high for the whole delay.
- R6: `irqPulse` and `smiPulse` are single-cycle pulses that always occur together, and only when an operation completes.
- R7: An `accessReq` pulse that arrives while the block is busy is held, not lost. It produces its `accessStart` or `probeStart` in the cycle after completion, and no access starts before that.
- R8: A timed-mode write, and a poll that timed out, leave no poll pending: the next request starts its access directly.
- R9: Reset clears `busy`, all pulse outputs, the delay timer and any pending poll. After a fast-mode write followed by reset, a request starts its access with no probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timedWrite | input | 1 | 1 selects delayed completion for writes, sampled with `lastBitDone` |
| accessReq | input | 1 | One-cycle request for a new EEPROM access |
| lastBitDone | input | 1 | Shifter strobe: last bit of the current operation sent |
| opIsWrite | input | 1 | Qualifies `lastBitDone`: 1 for a write, 0 for a read |
| probeDone | input | 1 | Result of an address probe is valid |
| probeAck | input | 1 | The probe was acknowledged by the device |
| busy | output | 1 | Start/busy status, high from access start to completion |
| irqPulse | output | 1 | One-cycle completion interrupt |
| smiPulse | output | 1 | One-cycle system-management request at completion |
| accessStart | output | 1 | One-cycle command to the shifter to begin the access |
| probeStart | output | 1 | One-cycle command to send an address probe |
| pollTimeout | output | 1 | One-cycle error: probe retry limit reached |

## Verification
The assertions check on every cycle that the two completion pulses come together and last one cycle, that `busy` falls only on completion or on a poll timeout, and that a probe and an access never start in the same cycle. They also check that a timeout starts nothing. A counter in the checker confirms the exact timed-mode delay and that `busy` holds throughout it. Only the bench scenarios can show sequence-level behaviour: that polling is armed by a fast-mode write and not by a read or a timed write, the retry count before a timeout, a request held across a delay, and reset discarding a pending poll.

// File: rtl/eeprom_wdone_pkg.sv
`timescale 1ns/1ps
package eeprom_wdone_pkg;
  // 10.24 ms counted in 10 us ticks
  localparam int DELAY_TICKS = 1024;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WAIT = 2'd2,
    ST_POLL = 2'd3
  } state_t;

  typedef struct packed {
    logic timerRun;
    logic retryClr;
    logic retryInc;
  } strobe_t;
endpackage

// File: rtl/eeprom_wdone_timer.sv
`timescale 1ns/1ps
module eeprom_wdone_timer
  import eeprom_wdone_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int MAX_RETRY = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    timerExpire,
  output logic    retryLast
);
  localparam int TICK_CYC = CLK_KHZ / 100;
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int DW = $clog2(DELAY_TICKS);
  localparam int RW = (MAX_RETRY > 1) ? $clog2(MAX_RETRY) : 1;

  logic [PW-1:0] presc;
  logic [DW-1:0] ticks;
  logic [RW-1:0] retry;
  logic tickNow;

  assign tickNow     = stb.timerRun && (presc == PW'(TICK_CYC - 1));
  assign timerExpire = tickNow && (ticks == DW'(DELAY_TICKS - 1));
  assign retryLast   = (retry == RW'(MAX_RETRY - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !stb.timerRun) begin
      presc <= '0;
      ticks <= '0;
    end else if (tickNow) begin
      presc <= '0;
      ticks <= ticks + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.retryClr) retry <= '0;
    else if (stb.retryInc)     retry <= retry + 1'b1;
  end
endmodule

// File: rtl/eeprom_wdone_ctrl.sv
`timescale 1ns/1ps
module eeprom_wdone_ctrl
  import eeprom_wdone_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    timedWrite,
  input  logic    accessReq,
  input  logic    lastBitDone,
  input  logic    opIsWrite,
  input  logic    probeDone,
  input  logic    probeAck,
  input  logic    timerExpire,
  input  logic    retryLast,
  output strobe_t stb,
  output state_t  state,
  output logic    irqPulse,
  output logic    smiPulse,
  output logic    accessStart,
  output logic    probeStart,
  output logic    pollTimeout
);
  logic pollPend;
  logic reqPend;
  logic serve;

  assign serve = (state == ST_IDLE) && (accessReq || reqPend);

  always_comb begin
    stb.timerRun = (state == ST_WAIT);
    stb.retryClr = (state != ST_POLL);
    stb.retryInc = (state == ST_POLL) && probeDone && !probeAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      pollPend    <= 1'b0;
      reqPend     <= 1'b0;
      irqPulse    <= 1'b0;
      smiPulse    <= 1'b0;
      accessStart <= 1'b0;
      probeStart  <= 1'b0;
      pollTimeout <= 1'b0;
    end else begin
      irqPulse    <= 1'b0;
      smiPulse    <= 1'b0;
      accessStart <= 1'b0;
      probeStart  <= 1'b0;
      pollTimeout <= 1'b0;
      reqPend     <= (reqPend || accessReq) && !serve;
      case (state)
        ST_IDLE: if (serve) begin
          if (pollPend) begin
            state      <= ST_POLL;
            probeStart <= 1'b1;
          end else begin
            state       <= ST_XFER;
            accessStart <= 1'b1;
          end
        end
        ST_XFER: if (lastBitDone) begin
          if (opIsWrite && timedWrite) begin
            state <= ST_WAIT;
          end else begin
            state    <= ST_IDLE;
            irqPulse <= 1'b1;
            smiPulse <= 1'b1;
            pollPend <= opIsWrite;
          end
        end
        ST_WAIT: if (timerExpire) begin
          state    <= ST_IDLE;
          irqPulse <= 1'b1;
          smiPulse <= 1'b1;
        end
        ST_POLL: if (probeDone) begin
          if (probeAck) begin
            state       <= ST_XFER;
            accessStart <= 1'b1;
            pollPend    <= 1'b0;
          end else if (retryLast) begin
            state       <= ST_IDLE;
            pollTimeout <= 1'b1;
            pollPend    <= 1'b0;
          end else begin
            probeStart <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_wdone.sv
`timescale 1ns/1ps
module eeprom_wdone
  import eeprom_wdone_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int MAX_RETRY = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic timedWrite,
  input  logic accessReq,
  input  logic lastBitDone,
  input  logic opIsWrite,
  input  logic probeDone,
  input  logic probeAck,
  output logic busy,
  output logic irqPulse,
  output logic smiPulse,
  output logic accessStart,
  output logic probeStart,
  output logic pollTimeout
);
  strobe_t stb;
  state_t  state;
  logic    timerExpire;
  logic    retryLast;

  eeprom_wdone_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .timedWrite(timedWrite), .accessReq(accessReq),
    .lastBitDone(lastBitDone), .opIsWrite(opIsWrite), .probeDone(probeDone),
    .probeAck(probeAck), .timerExpire(timerExpire), .retryLast(retryLast),
    .stb(stb), .state(state), .irqPulse(irqPulse), .smiPulse(smiPulse),
    .accessStart(accessStart), .probeStart(probeStart), .pollTimeout(pollTimeout)
  );

  eeprom_wdone_timer #(.CLK_KHZ(CLK_KHZ), .MAX_RETRY(MAX_RETRY)) u_timer (
    .clk(clk), .rstN(rstN), .stb(stb),
    .timerExpire(timerExpire), .retryLast(retryLast)
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/eeprom_wdone_chk.sv
`timescale 1ns/1ps
module eeprom_wdone_chk
  import eeprom_wdone_pkg::*;
#(
  parameter int CLK_KHZ = 200000
) (
  input logic   clk,
  input logic   rstN,
  input state_t state,
  input logic   timedWrite,
  input logic   lastBitDone,
  input logic   opIsWrite,
  input logic   busy,
  input logic   irqPulse,
  input logic   smiPulse,
  input logic   accessStart,
  input logic   probeStart,
  input logic   pollTimeout
);
  localparam int DELAY_CYC = DELAY_TICKS * (CLK_KHZ / 100);

  logic        waiting;
  logic [31:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waiting <= 1'b0;
      waitCnt <= '0;
    end else if (state == ST_XFER && lastBitDone && opIsWrite && timedWrite) begin
      waiting <= 1'b1;
      waitCnt <= '0;
    end else if (irqPulse) begin
      waiting <= 1'b0;
    end else if (waiting) begin
      waitCnt <= waitCnt + 1;
    end
  end

  assert_irq_smi_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse == smiPulse);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
  assert_busy_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (irqPulse || pollTimeout));
  assert_timed_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && waiting) |-> (waitCnt == DELAY_CYC));
  assert_timed_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !irqPulse) |-> busy);
  assert_probe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(probeStart && accessStart));
  assert_timeout_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    pollTimeout |-> (!busy && !irqPulse && !accessStart));
endmodule

bind eeprom_wdone eeprom_wdone_chk #(.CLK_KHZ(CLK_KHZ)) u_chk (
  .clk(clk), .rstN(rstN), .state(state), .timedWrite(timedWrite),
  .lastBitDone(lastBitDone), .opIsWrite(opIsWrite), .busy(busy),
  .irqPulse(irqPulse), .smiPulse(smiPulse), .accessStart(accessStart),
  .probeStart(probeStart), .pollTimeout(pollTimeout)
);

// File: tb/sim_eeprom_wdone.sv
`timescale 1ns/1ps
module sim_eeprom_wdone;
  localparam int CLK_KHZ   = 400;
  localparam int MAX_RETRY = 3;
  localparam int DT        = 1024 * (CLK_KHZ / 100);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timedWrite = 1'b0, accessReq = 1'b0, lastBitDone = 1'b0, opIsWrite = 1'b0;
  logic probeDone = 1'b0, probeAck = 1'b0;
  logic busy, irqPulse, smiPulse, accessStart, probeStart, pollTimeout;

  int total = 0;
  int bad = 0;
  bit expPoll = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_wdone #(.CLK_KHZ(CLK_KHZ), .MAX_RETRY(MAX_RETRY)) u0 (
    .clk(clk), .rstN(rstN), .timedWrite(timedWrite), .accessReq(accessReq),
    .lastBitDone(lastBitDone), .opIsWrite(opIsWrite), .probeDone(probeDone),
    .probeAck(probeAck), .busy(busy), .irqPulse(irqPulse), .smiPulse(smiPulse),
    .accessStart(accessStart), .probeStart(probeStart), .pollTimeout(pollTimeout)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pollArmed(bit wr, bit timed);
    return wr && !timed;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    tick(); tick(); tick();
    rstN = 1'b1;
    expPoll = 1'b0;
  endtask

  // Issue a request; nacks = number of refused probes before an ack
  task automatic startAccess(int nacks, output bit started);
    started = 1'b0;
    accessReq = 1'b1;
    tick();
    accessReq = 1'b0;
    if (expPoll) begin
      chk("R3 probe first", probeStart, 1);
      chk("R3 no early start", accessStart, 0);
      for (int i = 0; i < MAX_RETRY; i++) begin
        probeDone = 1'b1;
        probeAck = (i >= nacks);
        tick();
        probeDone = 1'b0;
        probeAck = 1'b0;
        if (i >= nacks) begin
          chk("R3 start after ack", accessStart, 1);
          started = 1'b1;
          break;
        end else if (i == MAX_RETRY - 1) begin
          chk("R4 timeout", pollTimeout, 1);
          chk("R4 busy cleared", busy, 0);
          chk("R4 no irq", irqPulse, 0);
          chk("R4 no start", accessStart, 0);
        end else begin
          chk("R4 retry probe", probeStart, 1);
        end
      end
      expPoll = 1'b0;
    end else begin
      chk("R8 direct start", accessStart, 1);
      chk("R2 no probe", probeStart, 0);
      started = 1'b1;
    end
    if (started) chk("R7 busy on start", busy, 1);
  endtask

  task automatic finishOp(bit wr, bit timed, bit reqDuring);
    int n;
    int busyLow;
    int earlyStart;
    tick(); tick();
    lastBitDone = 1'b1;
    opIsWrite = wr;
    timedWrite = timed;
    tick();
    lastBitDone = 1'b0;
    timedWrite = 1'b0;
    if (wr && timed) begin
      n = 0; busyLow = 0; earlyStart = 0;
      while (!irqPulse && n < DT + 20) begin
        if (!busy) busyLow++;
        if (accessStart || probeStart) earlyStart++;
        accessReq = reqDuring && (n == 100);
        tick();
        n++;
      end
      accessReq = 1'b0;
      chk("R5 delay cycles", n, DT);
      chk("R5 busy held", busyLow, 0);
      chk("R7 stalled during delay", earlyStart, 0);
    end else begin
      chk("R1/R2 immediate irq", irqPulse, 1);
    end
    chk("R6 smi with irq", smiPulse, 1);
    chk("R1 busy drops", busy, 0);
    expPoll = pollArmed(wr, timed);
    if (reqDuring) begin
      tick();
      chk("R7 pending served", accessStart, 1);
      chk("R6 irq single", irqPulse, 0);
    end else begin
      tick();
      chk("R6 irq single", irqPulse, 0);
      chk("R6 smi single", smiPulse, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit st;
    void'($urandom(32'd1234));
    doReset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset irq", irqPulse, 0);
    chk("R9 reset start", accessStart, 0);
    chk("R9 reset probe", probeStart, 0);

    // R2: read
    startAccess(0, st); finishOp(1'b0, 1'b0, 1'b0);
    // R3: fast write then polled access
    startAccess(0, st); finishOp(1'b1, 1'b0, 1'b0);
    startAccess(0, st); finishOp(1'b0, 1'b0, 1'b0);
    // R4: retries then ack
    startAccess(0, st); finishOp(1'b1, 1'b0, 1'b0);
    startAccess(2, st); finishOp(1'b0, 1'b0, 1'b0);
    // R4: timeout, then R8 direct start
    startAccess(0, st); finishOp(1'b1, 1'b0, 1'b0);
    startAccess(MAX_RETRY, st);
    chk("R4 not started", st, 0);
    startAccess(0, st); finishOp(1'b0, 1'b0, 1'b0);
    // R5/R7/R8: timed write with request during delay
    startAccess(0, st); finishOp(1'b1, 1'b1, 1'b1);
    finishOp(1'b0, 1'b0, 1'b0);
    // R2: read with timed mode set completes at once
    startAccess(0, st); finishOp(1'b0, 1'b1, 1'b0);
    chk("R2 no poll after read", expPoll, 0);
    // R9: reset discards pending poll
    startAccess(0, st); finishOp(1'b1, 1'b0, 1'b0);
    doReset();
    chk("R9 busy after reset", busy, 0);
    startAccess(0, st); finishOp(1'b0, 1'b0, 1'b0);

    // constrained random mix
    for (int k = 0; k < 10; k++) begin
      bit wr, tm;
      int nk;
      wr = 1'($urandom % 2);
      tm = (($urandom % 4) == 0);
      nk = int'($urandom % (MAX_RETRY + 1));
      startAccess(nk, st);
      if (st) finishOp(wr, tm, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule